// File: doc/BRIEF.md
# Delegated Counter Window

This block lets supervisor software reach a small bank of machine-level event counters, and the configuration word of each counter, without direct machine-mode access. Software writes an index into a select register held elsewhere. It then accesses one of four window aliases, which the block receives as a request kind together with the select value. The block turns the select value into a counter slot and picks the target from the alias: the low or high word of the counter, or the low or high word of its configuration/event word. It then runs a fixed chain of permission and feature checks. A request that passes is served. A request that fails gets an illegal-instruction fault, a virtual-instruction fault or a plain rejection.

Two more request kinds are handled next to the window. The first reads an overflow summary, which collects the top bit of each event word. The second reads or writes a supervisor counter-inhibit shadow that freezes counting per slot. Every request gets a registered response one cycle later. A read returns the value the register held before any update in that same cycle. Counters advance on their event strobes, and a software write takes priority over an increment.

There is no multi-cycle control, so the design has no state machine. Each request is classified into one route: none, counter low, counter high, config low, config high, overflow summary or inhibit. The response register then moves from idle to holding one response, and back, on every cycle.

Top module: `ctrdel_window`

## Requirements
- R1: After reset, every counter, every configuration/event word and the inhibit shadow are zero, and `rsp_valid` is low.
- R2: A request with `req_valid` high yields `rsp_valid` high in the next cycle only. `rsp_fault` carries 0 (served), 1 (illegal instruction), 2 (virtual instruction) or 3 (rejected). `rsp_err` is high exactly when `rsp_fault` is non-zero, and `rsp_rdata` is zero in that case.
- R3: Window kinds 0..3 (counter low, config low, counter high, config high) and the inhibit kind 5 return fault 1 when `feat_deleg` or `feat_ccfg` is low.
- R4: On kinds 0..3, a select value of base+1 (reserved slot), below base, or at base+NCTR and above returns fault 3.
- R5: Kinds 2 and 3 return fault 1 when `mode_rv32` is low. The undefined kinds 6 and 7 always return fault 1.
- R6: On kinds 0..3, a slot whose `ctr_en` bit is clear, or any request while `deleg_on` is low, returns fault 3.
- R7: A window mask must be all zeros (read) or all ones (write). Only the low 32 mask bits count when `mode_rv32` is high. Any other mask returns fault 3.
- R8: Kind 0 reaches the full 64-bit counter in 64-bit mode and bits 31:0 in 32-bit mode. Kind 2 reaches counter bits 63:32. In 32-bit mode, bits 63:32 of the read data are zero.
- R9: Bit 62 of each configuration/event word is the machine-inhibit bit. It reads as zero through kinds 1 and 3 (bit 30 of the high half), and no window write changes it.
- R10: When `feat_cntrpmf` is low, kinds 1 and 3 on slots 0 and 2 return fault 3. When `feat_ofpmf` is low, kind 3 on slots 3 and above returns fault 3.
- R11: In 32-bit mode, a write to one half of a counter or event word leaves the other half as stored, so the 64-bit value is the two halves combined.
- R12: A counter other than slot 1 increments once per cycle while its `evt_strobe` bit is high and its inhibit bit is clear. A window write to that counter in the same cycle wins over the increment. An inhibit write (kind 5) merges data under the mask, and bit 1 always stays zero.
- R13: Kind 4 returns fault 2 when `feat_ofpmf`, `feat_ccfg`, `deleg_on` and `virt_on` are all high. It returns fault 1 for a non-zero mask. Otherwise it returns a vector with bit i equal to bit 63 of event word i, for i of 3 and above. Kind 5 returns fault 2 when `virt_on` is high.
- R14: A request that faults changes no stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_deleg | input | 1 | Counter delegation feature present |
| feat_ccfg | input | 1 | Supervisor counter configuration feature present |
| feat_cntrpmf | input | 1 | Cycle/instret configuration feature present |
| feat_ofpmf | input | 1 | Overflow/filter feature present |
| mode_rv32 | input | 1 | 32-bit register width mode |
| virt_on | input | 1 | Hart is in virtualized mode |
| deleg_on | input | 1 | Global delegation enable from machine environment config |
| ctr_en | input | NCTR | Per-slot machine counter-enable mask |
| evt_strobe | input | NCTR | Per-slot count event |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind (0..5 defined) |
| req_sel | input | SELW | Select register value |
| req_wmask | input | 64 | Write mask |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is a fault |
| rsp_fault | output | 2 | Fault code |
| rsp_rdata | output | 64 | Read data (value before the request) |

## Verification
The bench goes after the ordering of the check chain. A reserved slot must reject even in 64-bit mode on a high alias, and the feature checks must raise illegal before any index check. A design with the chain misordered would return the wrong fault code for these requests. It also probes a partial mask and a cleared enable bit, then reads the target back. A design that let a refused write through would show the new data there. The inhibit-bit writes, the 32-bit half-word writes and a write landing while the counter's strobe is active are compared against a behavioural model every cycle. A design that leaked bit 62, clobbered the other half, or let the increment override the write would diverge from the model on the next read.

// File: rtl/ctrdel_pkg.sv
package ctrdel_pkg;

    localparam int DW         = 64;
    localparam int HALF       = DW / 2;
    localparam int MINH_BIT   = 62;
    localparam int OF_BIT     = 63;
    localparam int FIRST_PROG = 3;

    localparam logic [2:0] K_CTR_LO = 3'd0;
    localparam logic [2:0] K_CFG_LO = 3'd1;
    localparam logic [2:0] K_CTR_HI = 3'd2;
    localparam logic [2:0] K_CFG_HI = 3'd3;
    localparam logic [2:0] K_OVF    = 3'd4;
    localparam logic [2:0] K_INH    = 3'd5;

    typedef enum logic [1:0] {
        F_NONE    = 2'd0,
        F_ILLEGAL = 2'd1,
        F_VIRT    = 2'd2,
        F_REJECT  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        RT_NONE,
        RT_CTR_LO,
        RT_CTR_HI,
        RT_CFG_LO,
        RT_CFG_HI,
        RT_OVF,
        RT_INH
    } route_e;

endpackage

// File: rtl/ctrdel_decode.sv
module ctrdel_decode
    import ctrdel_pkg::*;
#(
    parameter int              NCTR     = 8,
    parameter int              SELW     = 12,
    parameter logic [SELW-1:0] SEL_BASE = 12'h040,
    localparam int             IW       = $clog2(NCTR)
) (
    input  logic [2:0]      kind,
    input  logic [SELW-1:0] sel,
    input  logic [DW-1:0]   wmask,
    input  logic            feat_deleg,
    input  logic            feat_ccfg,
    input  logic            feat_cntrpmf,
    input  logic            feat_ofpmf,
    input  logic            mode_rv32,
    input  logic            virt_on,
    input  logic            deleg_on,
    input  logic [NCTR-1:0] ctr_en,
    output route_e          route,
    output fault_e          fault,
    output logic            is_write,
    output logic [IW-1:0]   idx
);

    logic [SELW-1:0] off;
    logic            below, in_range, en_ok, feat_ok;
    logic            m_zero, m_ones;
    logic            is_alias, cfg_kind, hi_kind;

    assign off      = sel - SEL_BASE;
    assign below    = sel < SEL_BASE;
    assign in_range = !below && (off < SELW'(NCTR));
    assign idx      = off[IW-1:0];
    assign en_ok    = in_range && ctr_en[idx] && deleg_on;
    assign feat_ok  = feat_deleg && feat_ccfg;

    assign m_zero   = mode_rv32 ? (wmask[HALF-1:0] == '0) : (wmask == '0);
    assign m_ones   = mode_rv32 ? (&wmask[HALF-1:0]) : (&wmask);
    assign is_write = !m_zero;

    assign is_alias = (kind <= K_CFG_HI);
    assign cfg_kind = (kind == K_CFG_LO) || (kind == K_CFG_HI);
    assign hi_kind  = (kind == K_CTR_HI) || (kind == K_CFG_HI);

    always_comb begin
        unique case (kind)
            K_CTR_LO: route = RT_CTR_LO;
            K_CFG_LO: route = RT_CFG_LO;
            K_CTR_HI: route = RT_CTR_HI;
            K_CFG_HI: route = RT_CFG_HI;
            K_OVF:    route = RT_OVF;
            K_INH:    route = RT_INH;
            default:  route = RT_NONE;
        endcase
    end

    always_comb begin
        fault = F_NONE;
        if (is_alias) begin
            if (!feat_ok)
                fault = F_ILLEGAL;
            else if (off == SELW'(1))
                fault = F_REJECT;
            else if (hi_kind && !mode_rv32)
                fault = F_ILLEGAL;
            else if ((kind == K_CFG_HI) && !feat_ofpmf && (off >= SELW'(FIRST_PROG)))
                fault = F_REJECT;
            else if (cfg_kind && !feat_cntrpmf && (off < SELW'(FIRST_PROG)))
                fault = F_REJECT;
            else if (!en_ok)
                fault = F_REJECT;
            else if (!m_zero && !m_ones)
                fault = F_REJECT;
        end else if (route == RT_OVF) begin
            if (feat_ofpmf && feat_ccfg && deleg_on && virt_on)
                fault = F_VIRT;
            else if (!m_zero)
                fault = F_ILLEGAL;
        end else if (route == RT_INH) begin
            if (!feat_ok)
                fault = F_ILLEGAL;
            else if (virt_on)
                fault = F_VIRT;
        end else begin
            fault = F_ILLEGAL;
        end
    end

endmodule

// File: rtl/ctrdel_bank.sv
module ctrdel_bank
    import ctrdel_pkg::*;
#(
    parameter int  NCTR = 8,
    localparam int IW   = $clog2(NCTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  route_e          route,
    input  logic [IW-1:0]   idx,
    input  logic            mode_rv32,
    input  logic [DW-1:0]   wdata,
    input  logic [NCTR-1:0] inh_mask,
    input  logic [NCTR-1:0] evt_strobe,
    output logic [DW-1:0]   rd_data
);

    logic [DW-1:0]   ctr_q [NCTR];
    logic [DW-1:0]   evt_q [NCTR];
    logic [NCTR-1:0] inh_q;
    logic [NCTR-1:0] ovf_vec;

    logic [DW-1:0] ctr_cur, evt_cur, ctr_new, evt_new;
    logic          wr_ctr, wr_evt, wr_inh;

    assign ctr_cur = ctr_q[idx];
    assign evt_cur = evt_q[idx];

    assign wr_ctr = wr_en && ((route == RT_CTR_LO) || (route == RT_CTR_HI));
    assign wr_evt = wr_en && ((route == RT_CFG_LO) || (route == RT_CFG_HI));
    assign wr_inh = wr_en && (route == RT_INH);

    // New word for the addressed slot; the inhibit bit always keeps its stored value
    always_comb begin
        ctr_new = ctr_cur;
        evt_new = evt_cur;
        unique case (route)
            RT_CTR_LO: ctr_new = mode_rv32 ? {ctr_cur[DW-1:HALF], wdata[HALF-1:0]} : wdata;
            RT_CTR_HI: ctr_new = {wdata[HALF-1:0], ctr_cur[HALF-1:0]};
            RT_CFG_LO: begin
                if (mode_rv32)
                    evt_new = {evt_cur[DW-1:HALF], wdata[HALF-1:0]};
                else
                    evt_new = {wdata[OF_BIT], evt_cur[MINH_BIT], wdata[MINH_BIT-1:0]};
            end
            RT_CFG_HI: evt_new = {wdata[HALF-1], evt_cur[MINH_BIT],
                                  wdata[MINH_BIT-HALF-1:0], evt_cur[HALF-1:0]};
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTR; i++) begin
                ctr_q[i] <= '0;
                evt_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NCTR; i++) begin
                if (i != 1) begin
                    if (wr_ctr && (idx == IW'(i)))
                        ctr_q[i] <= ctr_new;
                    else if (evt_strobe[i] && !inh_q[i])
                        ctr_q[i] <= ctr_q[i] + 1'b1;
                    if (wr_evt && (idx == IW'(i)))
                        evt_q[i] <= evt_new;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            inh_q <= '0;
        else if (wr_inh)
            inh_q <= ((wdata[NCTR-1:0] & inh_mask) | (inh_q & ~inh_mask)) & ~NCTR'(2);
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_ovf
        if (g >= FIRST_PROG) begin : g_prog
            assign ovf_vec[g] = evt_q[g][OF_BIT];
        end else begin : g_fixed
            assign ovf_vec[g] = 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (route)
            RT_CTR_LO: rd_data = mode_rv32 ? {{HALF{1'b0}}, ctr_cur[HALF-1:0]} : ctr_cur;
            RT_CTR_HI: rd_data = {{HALF{1'b0}}, ctr_cur[DW-1:HALF]};
            RT_CFG_LO: begin
                if (mode_rv32)
                    rd_data = {{HALF{1'b0}}, evt_cur[HALF-1:0]};
                else
                    rd_data = {evt_cur[OF_BIT], 1'b0, evt_cur[MINH_BIT-1:0]};
            end
            RT_CFG_HI: rd_data = {{HALF{1'b0}}, evt_cur[OF_BIT], 1'b0,
                                  evt_cur[MINH_BIT-1:HALF]};
            RT_OVF:    rd_data = DW'(ovf_vec);
            RT_INH:    rd_data = DW'(inh_q);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ctrdel_window.sv
module ctrdel_window
    import ctrdel_pkg::*;
#(
    parameter int              NCTR     = 8,
    parameter int              SELW     = 12,
    parameter logic [SELW-1:0] SEL_BASE = 12'h040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            feat_deleg,
    input  logic            feat_ccfg,
    input  logic            feat_cntrpmf,
    input  logic            feat_ofpmf,
    input  logic            mode_rv32,
    input  logic            virt_on,
    input  logic            deleg_on,
    input  logic [NCTR-1:0] ctr_en,
    input  logic [NCTR-1:0] evt_strobe,
    input  logic            req_valid,
    input  logic [2:0]      req_kind,
    input  logic [SELW-1:0] req_sel,
    input  logic [63:0]     req_wmask,
    input  logic [63:0]     req_wdata,
    output logic            rsp_valid,
    output logic            rsp_err,
    output logic [1:0]      rsp_fault,
    output logic [63:0]     rsp_rdata
);

    localparam int IW = $clog2(NCTR);

    route_e        route;
    fault_e        fault;
    logic          is_write;
    logic [IW-1:0] idx;
    logic [DW-1:0] rd_data;
    logic          served;

    logic          valid_q;
    fault_e        fault_q;
    logic [DW-1:0] data_q;

    ctrdel_decode #(
        .NCTR     (NCTR),
        .SELW     (SELW),
        .SEL_BASE (SEL_BASE)
    ) u_decode (
        .kind         (req_kind),
        .sel          (req_sel),
        .wmask        (req_wmask),
        .feat_deleg   (feat_deleg),
        .feat_ccfg    (feat_ccfg),
        .feat_cntrpmf (feat_cntrpmf),
        .feat_ofpmf   (feat_ofpmf),
        .mode_rv32    (mode_rv32),
        .virt_on      (virt_on),
        .deleg_on     (deleg_on),
        .ctr_en       (ctr_en),
        .route        (route),
        .fault        (fault),
        .is_write     (is_write),
        .idx          (idx)
    );

    assign served = req_valid && (fault == F_NONE);

    ctrdel_bank #(
        .NCTR (NCTR)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (served && is_write),
        .route      (route),
        .idx        (idx),
        .mode_rv32  (mode_rv32),
        .wdata      (req_wdata),
        .inh_mask   (req_wmask[NCTR-1:0]),
        .evt_strobe (evt_strobe),
        .rd_data    (rd_data)
    );

    // Response register: idle when no request, holds one response otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            fault_q <= F_NONE;
            data_q  <= '0;
        end else begin
            valid_q <= req_valid;
            fault_q <= req_valid ? fault : F_NONE;
            data_q  <= served ? rd_data : '0;
        end
    end

    always_comb begin
        rsp_valid = valid_q;
        rsp_fault = fault_q;
        rsp_err   = (fault_q != F_NONE);
        rsp_rdata = data_q;
    end

endmodule

// File: rtl/ctrdel_window_chk.sv
module ctrdel_window_chk #(
    parameter int              NCTR     = 8,
    parameter int              SELW     = 12,
    parameter logic [SELW-1:0] SEL_BASE = 12'h040
) (
    input logic            clk,
    input logic            rst_n,
    input logic            feat_deleg,
    input logic            feat_ccfg,
    input logic            feat_cntrpmf,
    input logic            feat_ofpmf,
    input logic            mode_rv32,
    input logic            virt_on,
    input logic            deleg_on,
    input logic [NCTR-1:0] ctr_en,
    input logic [NCTR-1:0] evt_strobe,
    input logic            req_valid,
    input logic [2:0]      req_kind,
    input logic [SELW-1:0] req_sel,
    input logic [63:0]     req_wmask,
    input logic [63:0]     req_wdata,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic [1:0]      rsp_fault,
    input logic [63:0]     rsp_rdata
);

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_err_zero_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'd0));

    p_no_feature_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !feat_deleg && (req_kind <= 3'd3)) |=> (rsp_fault == 2'd1));

    p_reserved_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_deleg && feat_ccfg && (req_kind <= 3'd3) &&
         (req_sel == SEL_BASE + SELW'(1))) |=> (rsp_fault == 2'd3));

    p_high_alias_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_deleg && feat_ccfg && !mode_rv32 && (req_kind == 3'd2) &&
         (req_sel != SEL_BASE + SELW'(1))) |=> (rsp_fault == 2'd1));

    p_deleg_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_deleg && feat_ccfg && !deleg_on && (req_kind == 3'd0))
        |=> (rsp_fault == 2'd3));

    p_narrow_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_rv32 && (req_kind <= 3'd3)) |=> (rsp_rdata[63:32] == 32'd0));

    p_minh_hidden_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_rv32 && (req_kind == 3'd1)) |=> !rsp_rdata[62]);

    p_inhibit_virt_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_deleg && feat_ccfg && virt_on && (req_kind == 3'd5))
        |=> (rsp_fault == 2'd2));

endmodule

bind ctrdel_window ctrdel_window_chk #(
    .NCTR     (NCTR),
    .SELW     (SELW),
    .SEL_BASE (SEL_BASE)
) u_chk (.*);

// File: tb/ctrdel_window_test.sv
`timescale 1ns/1ps
module ctrdel_window_test;

    localparam int BASE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_deleg = 1'b1, feat_ccfg = 1'b1, feat_cntrpmf = 1'b1, feat_ofpmf = 1'b1;
    logic        mode_rv32 = 1'b0, virt_on = 1'b0, deleg_on = 1'b1;
    logic [7:0]  ctr_en = 8'hFF, evt_strobe = 8'h00;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [11:0] req_sel = 12'd0;
    logic [63:0] req_wmask = 64'd0, req_wdata = 64'd0;
    logic        rsp_valid, rsp_err;
    logic [1:0]  rsp_fault;
    logic [63:0] rsp_rdata;

    int    n_run = 0, n_fail = 0;
    string cur_tag = "R1";
    logic [1:0]  got_fault;
    logic [63:0] got_data;

    always #4 clk = ~clk;

    ctrdel_window uut (
        .clk(clk), .rst_n(rst_n),
        .feat_deleg(feat_deleg), .feat_ccfg(feat_ccfg),
        .feat_cntrpmf(feat_cntrpmf), .feat_ofpmf(feat_ofpmf),
        .mode_rv32(mode_rv32), .virt_on(virt_on), .deleg_on(deleg_on),
        .ctr_en(ctr_en), .evt_strobe(evt_strobe),
        .req_valid(req_valid), .req_kind(req_kind), .req_sel(req_sel),
        .req_wmask(req_wmask), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
    );

    // Behavioural reference model
    logic [63:0] m_ctr [8];
    logic [63:0] m_cfg [8];
    logic [7:0]  m_inh;
    logic        e_valid;
    logic [1:0]  e_fault;
    logic [63:0] e_data;

    always @(posedge clk) begin
        int k, ix;
        bit zero, ones;
        bit [7:0] written;
        logic [7:0] old_inh;
        logic [1:0] f;
        logic [63:0] d;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_ctr[i] = 0; m_cfg[i] = 0; end
            m_inh = 0; e_valid = 0; e_fault = 0; e_data = 0;
        end else begin
            f = 0; d = 0; written = 0; old_inh = m_inh;
            k = req_kind; ix = int'(req_sel) - BASE;
            zero = mode_rv32 ? (req_wmask[31:0] == 0) : (req_wmask == 0);
            ones = mode_rv32 ? (&req_wmask[31:0]) : (&req_wmask);
            if (req_valid) begin
                if (k <= 3) begin
                    if (!(feat_deleg && feat_ccfg)) f = 1;
                    else if (ix == 1) f = 3;
                    else if (k >= 2 && !mode_rv32) f = 1;
                    else if (k == 3 && !feat_ofpmf && ix >= 3) f = 3;
                    else if ((k == 1 || k == 3) && !feat_cntrpmf && ix < 3) f = 3;
                    else if (ix < 0 || ix >= 8) f = 3;
                    else if (!ctr_en[ix] || !deleg_on) f = 3;
                    else if (!zero && !ones) f = 3;
                    if (f == 0) begin
                        case (k)
                            0: begin
                                d = mode_rv32 ? {32'd0, m_ctr[ix][31:0]} : m_ctr[ix];
                                if (!zero) begin
                                    if (mode_rv32) m_ctr[ix][31:0] = req_wdata[31:0];
                                    else m_ctr[ix] = req_wdata;
                                    written[ix] = 1;
                                end
                            end
                            2: begin
                                d = {32'd0, m_ctr[ix][63:32]};
                                if (!zero) begin m_ctr[ix][63:32] = req_wdata[31:0]; written[ix] = 1; end
                            end
                            1: begin
                                d = mode_rv32 ? {32'd0, m_cfg[ix][31:0]} : m_cfg[ix];
                                d[62] = 1'b0;
                                if (!zero) begin
                                    if (mode_rv32) m_cfg[ix][31:0] = req_wdata[31:0];
                                    else m_cfg[ix] = {req_wdata[63], m_cfg[ix][62], req_wdata[61:0]};
                                end
                            end
                            default: begin
                                d = {32'd0, m_cfg[ix][63:32]};
                                d[30] = 1'b0;
                                if (!zero)
                                    m_cfg[ix][63:32] = {req_wdata[31], m_cfg[ix][62], req_wdata[29:0]};
                            end
                        endcase
                    end
                end else if (k == 4) begin
                    if (feat_ofpmf && feat_ccfg && deleg_on && virt_on) f = 2;
                    else if (!zero) f = 1;
                    else for (int i = 3; i < 8; i++) d[i] = m_cfg[i][63];
                end else if (k == 5) begin
                    if (!(feat_deleg && feat_ccfg)) f = 1;
                    else if (virt_on) f = 2;
                    else begin
                        d = {56'd0, m_inh};
                        if (!zero)
                            m_inh = ((req_wdata[7:0] & req_wmask[7:0]) |
                                     (m_inh & ~req_wmask[7:0])) & 8'hFD;
                    end
                end else begin
                    f = 1;
                end
            end
            for (int i = 0; i < 8; i++)
                if (i != 1 && !written[i] && evt_strobe[i] && !old_inh[i])
                    m_ctr[i] = m_ctr[i] + 1;
            e_valid = req_valid;
            e_fault = req_valid ? f : 2'd0;
            e_data  = (req_valid && f == 0) ? d : 64'd0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_run++;
            if ({rsp_valid, rsp_err, rsp_fault, rsp_rdata} !==
                {e_valid, (e_fault != 2'd0), e_fault, e_data}) begin
                n_fail++;
                $display("FAIL R2 model (%s): got v%b e%b f%0d d%h expected v%b f%0d d%h",
                         cur_tag, rsp_valid, rsp_err, rsp_fault, rsp_rdata,
                         e_valid, e_fault, e_data);
            end
        end
    end

    task automatic req(input logic [2:0] k, input logic [11:0] s,
                       input logic [63:0] m, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_sel = s; req_wmask = m; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_wmask = 64'd0; req_wdata = 64'd0;
        got_fault = rsp_fault;
        got_data  = rsp_rdata;
    endtask

    localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1";
        chk("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        req(3'd0, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R1 counter3 reset value", got_data, 64'd0);
        chk("R1 read fault", {62'd0, got_fault}, 64'd0);

        // R8: full-width counter write and read
        cur_tag = "R8";
        req(3'd0, 12'(BASE + 3), ALL, 64'h1234_5678_9ABC_DEF0);
        req(3'd0, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R8 counter3 readback", got_data, 64'h1234_5678_9ABC_DEF0);

        // R9: machine-inhibit bit hidden and protected
        cur_tag = "R9";
        req(3'd1, 12'(BASE + 4), ALL, ALL);
        req(3'd1, 12'(BASE + 4), 64'd0, 64'd0);
        chk("R9 event4 bit62 hidden", got_data, 64'hBFFF_FFFF_FFFF_FFFF);

        // R4: reserved and out-of-range slots
        cur_tag = "R4";
        req(3'd0, 12'(BASE + 1), 64'd0, 64'd0);
        chk("R4 reserved slot", {62'd0, got_fault}, 64'd3);
        req(3'd2, 12'(BASE + 1), 64'd0, 64'd0);
        chk("R4 reserved before width check", {62'd0, got_fault}, 64'd3);
        req(3'd0, 12'(BASE + 8), 64'd0, 64'd0);
        chk("R4 above range", {62'd0, got_fault}, 64'd3);
        req(3'd0, 12'(BASE - 1), 64'd0, 64'd0);
        chk("R4 below base", {62'd0, got_fault}, 64'd3);

        // R5: high aliases in 64-bit mode, undefined kinds
        cur_tag = "R5";
        req(3'd2, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R5 high alias wide mode", {62'd0, got_fault}, 64'd1);
        req(3'd7, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R5 undefined kind", {62'd0, got_fault}, 64'd1);

        // R6: enable gating
        cur_tag = "R6";
        ctr_en = 8'hF7;
        req(3'd0, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R6 slot enable clear", {62'd0, got_fault}, 64'd3);
        ctr_en = 8'hFF; deleg_on = 1'b0;
        req(3'd0, 12'(BASE + 3), ALL, 64'd5);
        chk("R6 delegation off", {62'd0, got_fault}, 64'd3);
        deleg_on = 1'b1;

        // R7 and R14: partial mask refused, nothing written
        cur_tag = "R7";
        req(3'd0, 12'(BASE + 3), 64'hFF, 64'd0);
        chk("R7 partial mask", {62'd0, got_fault}, 64'd3);
        req(3'd0, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R14 counter3 untouched", got_data, 64'h1234_5678_9ABC_DEF0);

        // R10: feature dependencies
        cur_tag = "R10";
        feat_cntrpmf = 1'b0;
        req(3'd1, 12'(BASE + 0), 64'd0, 64'd0);
        chk("R10 cycle config without feature", {62'd0, got_fault}, 64'd3);
        req(3'd1, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R10 event config still served", {62'd0, got_fault}, 64'd0);
        feat_cntrpmf = 1'b1; feat_ofpmf = 1'b0; mode_rv32 = 1'b1;
        req(3'd3, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R10 event high without overflow feature", {62'd0, got_fault}, 64'd3);
        feat_ofpmf = 1'b1; mode_rv32 = 1'b0;

        // R3: features absent
        cur_tag = "R3";
        feat_deleg = 1'b0;
        req(3'd0, 12'(BASE + 1), 64'd0, 64'd0);
        chk("R3 delegation absent", {62'd0, got_fault}, 64'd1);
        req(3'd5, 12'd0, 64'd0, 64'd0);
        chk("R3 inhibit with delegation absent", {62'd0, got_fault}, 64'd1);
        feat_deleg = 1'b1;

        // R13: overflow summary and virtualization
        cur_tag = "R13";
        req(3'd1, 12'(BASE + 5), ALL, 64'h8000_0000_0000_0000);
        virt_on = 1'b1;
        req(3'd4, 12'd0, 64'd0, 64'd0);
        chk("R13 summary in virtual mode", {62'd0, got_fault}, 64'd2);
        req(3'd5, 12'd0, 64'd0, 64'd0);
        chk("R13 inhibit in virtual mode", {62'd0, got_fault}, 64'd2);
        virt_on = 1'b0;
        req(3'd4, 12'd0, 64'd0, 64'd0);
        chk("R13 summary bits", got_data, 64'h30);
        req(3'd4, 12'd0, 64'd1, 64'd0);
        chk("R13 summary write", {62'd0, got_fault}, 64'd1);

        // R11: 32-bit half writes
        cur_tag = "R11";
        mode_rv32 = 1'b1;
        req(3'd3, 12'(BASE + 6), 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        req(3'd3, 12'(BASE + 6), 64'd0, 64'd0);
        chk("R11 event6 high half", got_data, 64'hBFFF_FFFF);
        req(3'd1, 12'(BASE + 6), 64'hFFFF_FFFF, 64'h11);
        req(3'd2, 12'(BASE + 3), 64'hFFFF_FFFF, 64'h77);
        req(3'd0, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R11 counter3 low half kept", got_data, 64'h9ABC_DEF0);
        mode_rv32 = 1'b0;
        req(3'd1, 12'(BASE + 6), 64'd0, 64'd0);
        chk("R11 event6 combined", got_data, 64'hBFFF_FFFF_0000_0011);

        // R12: counting, inhibit, write priority
        cur_tag = "R12";
        req(3'd5, 12'd0, ALL, 64'h0A);
        req(3'd5, 12'd0, 64'd0, 64'd0);
        chk("R12 inhibit bit1 stays zero", got_data, 64'h08);
        req(3'd0, 12'(BASE + 3), ALL, 64'd0);
        req(3'd0, 12'(BASE + 5), ALL, 64'd0);
        @(negedge clk);
        evt_strobe = 8'h28;
        repeat (4) @(negedge clk);
        evt_strobe = 8'h00;
        req(3'd0, 12'(BASE + 5), 64'd0, 64'd0);
        chk("R12 counter5 counted", got_data, 64'd4);
        req(3'd0, 12'(BASE + 3), 64'd0, 64'd0);
        chk("R12 counter3 inhibited", got_data, 64'd0);
        @(negedge clk);
        evt_strobe = 8'h20;
        req(3'd0, 12'(BASE + 5), ALL, 64'd100);
        evt_strobe = 8'h00;
        req(3'd0, 12'(BASE + 5), 64'd0, 64'd0);
        chk("R12 write wins over increment", got_data, 64'd100);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule